// File: doc/BRIEF.md
# Comparator Pulse Hit Detector

The block sits between a bank of comparators and a pipeline memory that is written every clock. Each comparator drives a level that has no fixed relation to the clock. The block turns every such level into one hit bit per channel per clock, so a full word of hits is ready to be stored on every cycle. All channels share one clock, one synchronous reset and one mode select.

There are two ways to form the hit. In follow mode the hit bit is the comparator level passed through a two-flop synchroniser, so its width tracks the pulse width and a pulse that falls between two clock edges is lost. In one-shot mode a rising comparator edge is caught by a per-channel flop clocked by the comparator itself. The caught edge is synchronised and then turned into a hit that lasts exactly one clock, whatever the pulse width. The catch is released once the hit has gone out. When the mode changes, the synchroniser chains and any pending catches are cleared, so the change produces no stray hit.

Top module: `hit_detect_top`

## Requirements
- R1: While reset is high every hit bit is 0, rising comparator edges seen during reset are dropped, and reset leaves the block in one-shot mode (mode_i = 0 selects one-shot, mode_i = 1 selects follow).
- R2: In follow mode the hit bit of a channel, observed after clock edge k, equals the comparator level sampled at clock edge k-1.
- R3: In follow mode a comparator pulse that rises and falls between two clock edges produces no hit.
- R4: In one-shot mode a rising comparator edge, including one from a pulse shorter than a clock period, makes the hit bit high for exactly one cycle: the cycle after the second clock edge that follows the rise.
- R5: In one-shot mode a pulse that stays high for several clocks gives one hit only, and a further hit requires the level to fall and rise again.
- R6: Channels are independent: simultaneous pulses of different widths on different channels give each channel its own result.
- R7: The clock edge at which mode_i is seen to differ from the current mode switches the mode and clears every channel, so all hit bits are 0 in the following cycle; a rising edge caught before the switch produces no hit, and a level that is already high when one-shot mode is entered produces no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset (also releases edge catches at once) |
| mode_i | input | 1 | 0 = one-shot hits, 1 = follow the synchronised level |
| comp_i | input | NUM_CH | Comparator levels, one per channel, asynchronous to clk_i |
| hit_o | output | NUM_CH | Hit bits, one per channel, valid every clock |

## Verification
A stuck edge catch shows up as a missing hit, or as a repeated hit on the next pulse of that channel, two cycles after the pulse rises. A synchroniser stage left set by a mode change appears as a hit bit high in the cycle right after the switch. A wrong stage count shifts every hit by whole cycles, which a per-clock comparison against an independently computed expectation catches on the first pulse. Hits that last two cycles in one-shot mode reveal a broken single-cycle former at once.

// File: rtl/hit_detect_pkg.sv
package hit_detect_pkg;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_FOLLOW  = 1'b1
    } hit_mode_e;

    // Per-channel synchroniser and pulse-former state.
    typedef struct packed {
        logic meta;   // first synchroniser flop
        logic sync;   // second synchroniser flop
        logic last;   // delayed copy used to find the rising edge
    } lane_state_t;

    localparam lane_state_t LANE_IDLE = '{meta: 1'b0, sync: 1'b0, last: 1'b0};

    function automatic logic form_hit(hit_mode_e m, lane_state_t st);
        if (m == MODE_FOLLOW) begin
            return st.sync;
        end
        return st.sync & ~st.last;
    endfunction

    function automatic lane_state_t lane_step(lane_state_t st, logic din);
        lane_state_t nx;
        nx.meta = din;
        nx.sync = st.meta;
        nx.last = st.sync;
        return nx;
    endfunction

endpackage

// File: rtl/hit_mode_ctrl.sv
module hit_mode_ctrl
    import hit_detect_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      mode_i,
    output hit_mode_e mode_q_o,
    output logic      flush_o
);

    hit_mode_e mode_q;
    hit_mode_e mode_req;

    assign mode_req = hit_mode_e'(mode_i);
    assign flush_o  = (mode_req != mode_q);
    assign mode_q_o = mode_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= MODE_ONESHOT;
        end else if (flush_o) begin
            mode_q <= mode_req;
        end
    end

endmodule

// File: rtl/hit_edge_catch.sv
module hit_edge_catch (
    input  logic lvl_i,
    input  logic clr_i,
    output logic caught_o
);

    // Set by the comparator's own rising edge, so a pulse narrower than a
    // clock period is still recorded; released asynchronously by clr_i.
    always_ff @(posedge lvl_i or posedge clr_i) begin
        if (clr_i) begin
            caught_o <= 1'b0;
        end else begin
            caught_o <= 1'b1;
        end
    end

endmodule

// File: rtl/hit_sync_lane.sv
module hit_sync_lane
    import hit_detect_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      flush_i,
    input  hit_mode_e mode_i,
    input  logic      lvl_i,
    input  logic      caught_i,
    output logic      release_o,
    output logic      hit_o
);

    lane_state_t st_q;
    logic        din;

    assign din = (mode_i == MODE_FOLLOW) ? lvl_i : caught_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || flush_i) begin
            st_q <= LANE_IDLE;
        end else begin
            st_q <= lane_step(st_q, din);
        end
    end

    assign hit_o     = form_hit(mode_i, st_q);
    assign release_o = st_q.sync;

endmodule

// File: rtl/hit_detect_top.sv
module hit_detect_top
    import hit_detect_pkg::*;
#(
    parameter int NUM_CH = 128
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mode_i,
    input  logic [NUM_CH-1:0] comp_i,
    output logic [NUM_CH-1:0] hit_o
);

    hit_mode_e   mode_q;
    logic        flush;
    logic        hold_clear;
    logic [NUM_CH-1:0] caught;
    logic [NUM_CH-1:0] released;
    logic [NUM_CH-1:0] clr;

    hit_mode_ctrl u_mode (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mode_i   (mode_i),
        .mode_q_o (mode_q),
        .flush_o  (flush)
    );

    // Catches are held clear in reset and in follow mode, so entering
    // one-shot mode always starts with nothing pending.
    assign hold_clear = rst_i | (mode_q == MODE_FOLLOW);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign clr[ch] = hold_clear | released[ch];

        hit_edge_catch u_catch (
            .lvl_i    (comp_i[ch]),
            .clr_i    (clr[ch]),
            .caught_o (caught[ch])
        );

        hit_sync_lane u_lane (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .flush_i   (flush),
            .mode_i    (mode_q),
            .lvl_i     (comp_i[ch]),
            .caught_i  (caught[ch]),
            .release_o (released[ch]),
            .hit_o     (hit_o[ch])
        );
    end

endmodule

// File: rtl/hit_detect_chk.sv
module hit_detect_chk #(
    parameter int NUM_CH = 128
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              mode_i,
    input logic              mode_q,
    input logic [NUM_CH-1:0] comp_i,
    input logic [NUM_CH-1:0] hit_o
);

    // R1: a reset cycle leaves all hit bits low
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        rst_i |=> (hit_o == '0));

    // R7: a mode change empties every lane
    a_r7_switch_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i != mode_q) |=> (hit_o == '0));

    // R4: in one-shot mode no hit bit stays high two cycles running
    a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q == 1'b0 && $past(mode_q) == 1'b0) |-> ((hit_o & $past(hit_o)) == '0));

    // R2: in steady follow mode the hit is the level two edges back
    a_r2_follow_delay: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q == 1'b1 && $past(mode_q) == 1'b1 && $past(mode_q, 2) == 1'b1)
        |-> (hit_o == $past(comp_i, 2)));

endmodule

bind hit_detect_top hit_detect_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mode_i (mode_i),
    .mode_q (mode_q),
    .comp_i (comp_i),
    .hit_o  (hit_o)
);

// File: tb/hit_detect_top_tb_top.sv
module hit_detect_top_tb_top;

    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic           mode;
    logic [NCH-1:0] comp;
    logic [NCH-1:0] hit;

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    string phase = "R1";

    hit_detect_top #(.NUM_CH(NCH)) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .mode_i (mode),
        .comp_i (comp),
        .hit_o  (hit)
    );

    always #5 clk = ~clk;

    // Behavioural reference: count rising edges of the stimulus, then
    // predict from the requirements what each clock should show.
    int rise_cnt [NCH];
    int seen_cnt [NCH];
    initial for (int i = 0; i < NCH; i++) begin
        rise_cnt[i] = 0;
        seen_cnt[i] = 0;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_rise
        always @(posedge comp[g]) rise_cnt[g]++;
    end

    logic [NCH-1:0] rose;
    logic [NCH-1:0] p1 = '0;
    logic [NCH-1:0] p2 = '0;
    logic [NCH-1:0] exp_hit = '0;
    logic           mode_m = 1'b0;

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            rose[i] = (rise_cnt[i] != seen_cnt[i]);
            seen_cnt[i] = rise_cnt[i];
        end
        if (rst) begin
            mode_m = 1'b0;
            p1 = '0;
            p2 = '0;
        end else if (mode != mode_m) begin
            mode_m = mode;
            p1 = '0;
            p2 = '0;
        end else begin
            p2 = p1;
            p1 = mode_m ? comp : rose;
        end
        exp_hit = p2;
    end

    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (hit !== exp_hit) begin
                mismatched++;
                $display("FAIL %s t=%0t hit=%h expected=%h", phase, $time, hit, exp_hit);
            end
        end
    end

    task automatic edge_plus2();
        @(posedge clk);
        #2;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst  = 1'b1;
        mode = 1'b0;
        comp = '0;

        // R1: edges during reset leave no trace
        phase = "R1";
        idle(2);
        #2 comp[3] = 1'b1;
        #3 comp[3] = 1'b0;
        edge_plus2();
        comp[6] = 1'b1;
        #10 comp[6] = 1'b0;
        idle(2);
        #1 rst = 1'b0;
        idle(6);

        // R4: sub-period pulse is caught and gives a single-cycle hit
        phase = "R4";
        edge_plus2();
        comp[0] = 1'b1;
        #1 comp[0] = 1'b0;
        idle(8);
        edge_plus2();
        comp[0] = 1'b1;
        #10 comp[0] = 1'b0;
        idle(8);

        // R6: several channels, different widths, same moment
        phase = "R6";
        edge_plus2();
        comp = 16'h00A5 | 16'h0024;
        #3 comp[2] = 1'b0;
        #5 comp[0] = 1'b0;
        #17 comp = '0;
        idle(8);

        // R5: long pulse gives one hit; fall and rise gives another
        phase = "R5";
        edge_plus2();
        comp[1] = 1'b1;
        #50 comp[1] = 1'b0;
        idle(8);
        edge_plus2();
        comp[1] = 1'b1;
        #20 comp[1] = 1'b0;
        idle(8);

        // R7: edge caught just before a switch into follow mode is dropped
        phase = "R7";
        edge_plus2();
        comp[4] = 1'b1;
        mode = 1'b1;
        #1 comp[4] = 1'b0;
        idle(6);

        // R2: follow mode tracks held levels two edges late
        phase = "R2";
        edge_plus2();
        comp = 16'h3C0F;
        #30 comp = 16'h0FF0;
        #20 comp = 16'h8001;
        #10 comp = '0;
        idle(6);

        // R3: a pulse between two edges is missed in follow mode
        phase = "R3";
        edge_plus2();
        comp[7] = 1'b1;
        #4 comp[7] = 1'b0;
        idle(6);

        // R7: level already high when one-shot mode is entered
        phase = "R7";
        edge_plus2();
        comp[9] = 1'b1;
        idle(3);
        #2 mode = 1'b0;
        idle(6);
        #2 comp[9] = 1'b0;
        idle(6);

        // R5: after the fall, a new rise is a normal one-shot hit
        phase = "R5";
        edge_plus2();
        comp[9] = 1'b1;
        #15 comp[9] = 1'b0;
        idle(8);

        // R7: switch while a hit is being formed clears it
        phase = "R7";
        edge_plus2();
        comp[12] = 1'b1;
        #1 comp[12] = 1'b0;
        edge_plus2();
        mode = 1'b1;
        idle(6);
        #2 mode = 1'b0;
        idle(6);

        finish_run();
    end

endmodule